// File: doc/BRIEF.md
# Bi-mode conditional branch direction predictor

This block guesses whether a conditional branch will be taken. It keeps three tables of 2-bit saturating counters. A steering table is indexed by the branch address XORed with the global history. The most significant bit of the addressed steering counter picks one of two direction tables. One direction table starts out leaning towards taken and the other starts out leaning towards not-taken. Both direction tables are indexed by folding the global history onto itself. The most significant bit of the counter read from the chosen direction table is the prediction.

The front end presents the branch address bits on the request port. One cycle later it receives the direction and the history value that the prediction used. Each accepted prediction shifts its own predicted bit into a speculative global history. When the branch resolves, the back end returns the address, the actual outcome, the history snapshot and a mispredict flag. The block trains its counters from these. On a mispredict it also rebuilds the history from the snapshot with the true outcome appended.

Top module: `bimode_predictor`

## Requirements
- R1: `pred_rsp_valid` is high in exactly the cycle after each cycle in which `pred_valid` is high. It is low otherwise, including during and right after reset.
- R2: Right after reset, every request returns `pred_taken` = 0 and `pred_hist` = 0.
- R3: With P = the CIW-bit address input and H = a GHR_W-bit history, the steering index is P ^ H[CIW-1:0]. The direction index is H[GHR_W-1 -: DIW] ^ H[DIW-1:0].
- R4: A steering counter of 2 or 3 selects the taken-leaning table, and 0 or 1 selects the not-taken-leaning table. `pred_taken` is bit 1 of the selected direction counter, read before any update in the same cycle.
- R5: When a request is accepted and no restore happens in the same cycle, the history shifts left by one and the predicted bit enters at bit 0. `pred_hist` reports the history from before the shift.
- R6: When an update carries `upd_mispred` = 1, the history becomes {`upd_hist`[GHR_W-2:0], `upd_taken`}. This overrides a same-cycle speculative shift.
- R7: An update trains only the direction table that the steering counter selects at the update indices, one step towards the outcome and saturating at 0 and 3. The other direction table is left unchanged.
- R8: An update trains the steering counter towards the outcome, with one exception. If the steering choice disagrees with the outcome and the selected direction counter still predicted correctly, the steering counter is left unchanged.
- R9: Reset sets taken-leaning counters to 2, not-taken-leaning counters to 1 and steering counters to 1.
- R10: An update with `upd_mispred` = 0 and no request leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | CIW | Branch address bits above the instruction alignment offset |
| pred_rsp_valid | output | 1 | Response valid, one cycle after request |
| pred_taken | output | 1 | Predicted direction |
| pred_hist | output | GHR_W | History used by this prediction |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | CIW | Address bits of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_hist | input | GHR_W | History snapshot from prediction time |
| upd_mispred | input | 1 | Prediction was wrong; restore the history |

## Verification
On every cycle, the assertions check the response timing and all of the history register's movement: the speculative shift, the restore and its priority over the shift, and holding when idle. The counter training cannot be seen from a single cycle. The steering exception, the confinement of training to the selected table and the saturation limits show only in the bench's scenarios. There, a model built from the requirements predicts each direction after sequences of updates that alias on purpose in the tables.

// File: rtl/bimode_pkg.sv
package bimode_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_SNT = 2'd0;
    localparam ctr2_t CTR_WNT = 2'd1;
    localparam ctr2_t CTR_WT  = 2'd2;
    localparam ctr2_t CTR_ST  = 2'd3;

    typedef enum logic {
        SEL_NT_TABLE = 1'b0,
        SEL_TK_TABLE = 1'b1
    } dir_sel_e;

    // one saturating step towards the observed outcome
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t r;
        if (up) r = (c == CTR_ST)  ? CTR_ST  : c + 2'd1;
        else    r = (c == CTR_SNT) ? CTR_SNT : c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/bimode_hash.sv
module bimode_hash #(
    parameter int GHR_W = 22,
    parameter int CIW   = 10,
    parameter int DIW   = 11
) (
    input  logic [CIW-1:0]   pc,
    input  logic [GHR_W-1:0] hist,
    output logic [CIW-1:0]   cidx,
    output logic [DIW-1:0]   didx
);
    // steering: address bits mixed with recent history
    assign cidx = pc ^ hist[CIW-1:0];
    // direction: old history folded onto recent history
    assign didx = hist[GHR_W-1 -: DIW] ^ hist[DIW-1:0];
endmodule

// File: rtl/bimode_ctr_table.sv
module bimode_ctr_table
    import bimode_pkg::*;
#(
    parameter int    ENTRIES = 1024,
    parameter int    IW      = $clog2(ENTRIES),
    parameter ctr2_t INIT    = CTR_WNT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_dir,
    input  logic [IW-1:0] up_idx,
    output logic          up_dir,
    input  logic          wr_en,
    input  logic          wr_dir
);
    ctr2_t mem [ENTRIES];

    assign rd_dir = mem[rd_idx][1];
    assign up_dir = mem[up_idx][1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= INIT;
        end else if (wr_en) begin
            mem[up_idx] <= ctr_step(mem[up_idx], wr_dir);
        end
    end
endmodule

// File: rtl/bimode_ghr.sv
module bimode_ghr #(
    parameter int GHR_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spec_en,
    input  logic             spec_bit,
    input  logic             fix_en,
    input  logic [GHR_W-2:0] fix_hist,
    input  logic             fix_bit,
    output logic [GHR_W-1:0] ghr
);
    always_ff @(posedge clk) begin
        if (rst)          ghr <= '0;
        else if (fix_en)  ghr <= {fix_hist, fix_bit};
        else if (spec_en) ghr <= {ghr[GHR_W-2:0], spec_bit};
    end
endmodule

// File: rtl/bimode_predictor.sv
module bimode_predictor
    import bimode_pkg::*;
#(
    parameter int GHR_W          = 22,
    parameter int CHOICE_ENTRIES = 1024,
    parameter int DIR_ENTRIES    = 2048,
    parameter int CIW            = $clog2(CHOICE_ENTRIES),
    parameter int DIW            = $clog2(DIR_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pred_valid,
    input  logic [CIW-1:0]   pred_pc,
    output logic             pred_rsp_valid,
    output logic             pred_taken,
    output logic [GHR_W-1:0] pred_hist,
    input  logic             upd_valid,
    input  logic [CIW-1:0]   upd_pc,
    input  logic             upd_taken,
    input  logic [GHR_W-1:0] upd_hist,
    input  logic             upd_mispred
);
    localparam int PORTS = 2;  // 0: predict, 1: update

    logic [GHR_W-1:0] ghr_q;
    logic [CIW-1:0]   hs_pc   [PORTS];
    logic [GHR_W-1:0] hs_hist [PORTS];
    logic [CIW-1:0]   cidx    [PORTS];
    logic [DIW-1:0]   didx    [PORTS];

    assign hs_pc[0]   = pred_pc;
    assign hs_hist[0] = ghr_q;
    assign hs_pc[1]   = upd_pc;
    assign hs_hist[1] = upd_hist;

    for (genvar g = 0; g < PORTS; g++) begin : g_hash
        bimode_hash #(.GHR_W(GHR_W), .CIW(CIW), .DIW(DIW)) u_hash (
            .pc   (hs_pc[g]),
            .hist (hs_hist[g]),
            .cidx (cidx[g]),
            .didx (didx[g])
        );
    end

    // steering table
    logic     ch_rd_dir, ch_up_dir, ch_wr_en;
    dir_sel_e pred_sel, upd_sel;

    // direction tables, indexed by dir_sel_e value
    logic dir_rd [2];
    logic dir_up [2];
    logic dir_wr [2];

    assign pred_sel = dir_sel_e'(ch_rd_dir);
    assign upd_sel  = dir_sel_e'(ch_up_dir);

    logic pred_dir, upd_sel_right, keep_choice, upd_fix;

    assign pred_dir      = dir_rd[pred_sel];
    assign upd_sel_right = (dir_up[upd_sel] == upd_taken);
    assign keep_choice   = (ch_up_dir != upd_taken) && upd_sel_right;
    assign ch_wr_en      = upd_valid && !keep_choice;
    assign upd_fix       = upd_valid && upd_mispred;

    bimode_ctr_table #(.ENTRIES(CHOICE_ENTRIES), .IW(CIW), .INIT(CTR_WNT)) u_choice (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (cidx[0]),
        .rd_dir (ch_rd_dir),
        .up_idx (cidx[1]),
        .up_dir (ch_up_dir),
        .wr_en  (ch_wr_en),
        .wr_dir (upd_taken)
    );

    for (genvar t = 0; t < 2; t++) begin : g_dir
        localparam ctr2_t T_INIT = (t == int'(SEL_TK_TABLE)) ? CTR_WT : CTR_WNT;
        assign dir_wr[t] = upd_valid && (int'(upd_sel) == t);
        bimode_ctr_table #(.ENTRIES(DIR_ENTRIES), .IW(DIW), .INIT(T_INIT)) u_tab (
            .clk    (clk),
            .rst    (rst),
            .rd_idx (didx[0]),
            .rd_dir (dir_rd[t]),
            .up_idx (didx[1]),
            .up_dir (dir_up[t]),
            .wr_en  (dir_wr[t]),
            .wr_dir (upd_taken)
        );
    end

    bimode_ghr #(.GHR_W(GHR_W)) u_ghr (
        .clk      (clk),
        .rst      (rst),
        .spec_en  (pred_valid),
        .spec_bit (pred_dir),
        .fix_en   (upd_fix),
        .fix_hist (upd_hist[GHR_W-2:0]),
        .fix_bit  (upd_taken),
        .ghr      (ghr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_rsp_valid <= 1'b0;
            pred_taken     <= 1'b0;
            pred_hist      <= '0;
        end else begin
            pred_rsp_valid <= pred_valid;
            if (pred_valid) begin
                pred_taken <= pred_dir;
                pred_hist  <= ghr_q;
            end
        end
    end
endmodule

// File: rtl/bimode_predictor_chk.sv
module bimode_predictor_chk #(
    parameter int GHR_W = 22
) (
    input logic             clk,
    input logic             rst,
    input logic             pred_valid,
    input logic             pred_rsp_valid,
    input logic             pred_taken,
    input logic [GHR_W-1:0] pred_hist,
    input logic             upd_fix,
    input logic [GHR_W-2:0] upd_hist_lo,
    input logic             upd_taken,
    input logic [GHR_W-1:0] ghr
);
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        pred_valid |=> pred_rsp_valid);

    p_no_rsp_without_req_r1: assert property (@(posedge clk) disable iff (rst)
        !pred_valid |=> !pred_rsp_valid);

    p_hist_snapshot_r5: assert property (@(posedge clk) disable iff (rst)
        pred_valid |=> pred_hist == $past(ghr));

    p_spec_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !upd_fix) |=> ghr == {$past(ghr[GHR_W-2:0]), pred_taken});

    p_restore_r6: assert property (@(posedge clk) disable iff (rst)
        upd_fix |=> ghr == {$past(upd_hist_lo), $past(upd_taken)});

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!pred_valid && !upd_fix) |=> $stable(ghr));
endmodule

bind bimode_predictor bimode_predictor_chk #(.GHR_W(GHR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pred_valid     (pred_valid),
    .pred_rsp_valid (pred_rsp_valid),
    .pred_taken     (pred_taken),
    .pred_hist      (pred_hist),
    .upd_fix        (upd_fix),
    .upd_hist_lo    (upd_hist[GHR_W-2:0]),
    .upd_taken      (upd_taken),
    .ghr            (ghr_q)
);

// File: tb/bimode_predictor_tb.sv
module bimode_predictor_tb;
    localparam int GW  = 22;
    localparam int CE  = 1024;
    localparam int DE  = 2048;
    localparam int CIW = 10;
    localparam int DIW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pred_valid = 1'b0;
    logic [CIW-1:0] pred_pc = '0;
    logic          pred_rsp_valid, pred_taken;
    logic [GW-1:0] pred_hist;
    logic          upd_valid = 1'b0;
    logic [CIW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [GW-1:0] upd_hist = '0;
    logic          upd_mispred = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bimode_predictor u_dut (
        .clk(clk), .rst(rst),
        .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_rsp_valid(pred_rsp_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_hist(upd_hist), .upd_mispred(upd_mispred)
    );

    int checks = 0;
    int errors = 0;

    // requirement-level model state
    int            m_ch [CE];
    int            m_tk [DE];
    int            m_nt [DE];
    logic [GW-1:0] m_ghr;

    // scoreboard queues
    logic          q_dir [$];
    logic [GW-1:0] q_hist [$];
    string         q_tag [$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R3 index definitions
    function automatic int c_index(input logic [CIW-1:0] pc, input logic [GW-1:0] h);
        return int'(pc ^ h[CIW-1:0]);
    endfunction
    function automatic int d_index(input logic [GW-1:0] h);
        return int'(h[GW-1 -: DIW] ^ h[DIW-1:0]);
    endfunction
    function automatic int step_ctr(input int c, input logic up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < CE; i++) m_ch[i] = 1;  // R9
        for (int i = 0; i < DE; i++) begin
            m_tk[i] = 2;
            m_nt[i] = 1;
        end
        m_ghr = '0;
    endtask

    // driver: one cycle of stimulus, expectations pushed to the scoreboard
    task automatic step(input logic pv, input logic [CIW-1:0] ppc,
                        input logic uv, input logic [CIW-1:0] upc, input logic ut,
                        input logic [GW-1:0] uh, input logic um, input string tag);
        logic p;
        int   ci, di, cu, du, selc;
        logic sel, keep;
        @(posedge clk);
        #2;
        pred_valid = pv; pred_pc = ppc;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_hist = uh; upd_mispred = um;
        p = 1'b0;
        if (pv) begin
            ci = c_index(ppc, m_ghr);
            di = d_index(m_ghr);
            p  = (m_ch[ci] >= 2) ? (m_tk[di] >= 2) : (m_nt[di] >= 2);  // R4
            q_dir.push_back(p);
            q_hist.push_back(m_ghr);
            q_tag.push_back(tag);
        end
        if (uv) begin
            cu   = c_index(upc, uh);
            du   = d_index(uh);
            sel  = (m_ch[cu] >= 2);
            selc = sel ? m_tk[du] : m_nt[du];
            keep = (sel != ut) && ((selc >= 2) == ut);             // R8
            if (sel) m_tk[du] = step_ctr(m_tk[du], ut);            // R7
            else     m_nt[du] = step_ctr(m_nt[du], ut);
            if (!keep) m_ch[cu] = step_ctr(m_ch[cu], ut);
        end
        if (uv && um)  m_ghr = {uh[GW-2:0], ut};                   // R6
        else if (pv)   m_ghr = {m_ghr[GW-2:0], p};                 // R5
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "idle");
    endtask

    task automatic predict(input logic [CIW-1:0] pc, input string tag);
        step(1'b1, pc, 1'b0, '0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic train(input logic [CIW-1:0] pc, input logic t, input logic [GW-1:0] h,
                         input logic mis, input string tag);
        step(1'b0, '0, 1'b1, pc, t, h, mis, tag);
    endtask

    // history load via restore: resulting history is h
    task automatic load_hist(input logic [GW-1:0] h, input logic [CIW-1:0] pc);
        train(pc, h[0], {1'b0, h[GW-1:1]}, 1'b1, "load");
    endtask

    // monitor
    logic pv_d;
    always @(posedge clk) pv_d <= rst ? 1'b0 : pred_valid;

    always @(negedge clk) begin
        if (!rst) begin
            check("R1 response valid timing", {63'd0, pred_rsp_valid}, {63'd0, pv_d});
            if (pred_rsp_valid && q_dir.size() > 0) begin
                string t;
                t = q_tag.pop_front();
                check({t, " direction"}, {63'd0, pred_taken}, {63'd0, q_dir.pop_front()});
                check({t, " R5 history snapshot"}, {42'd0, pred_hist}, {42'd0, q_hist.pop_front()});
            end
        end
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R2 reset state at the ports
        check("R2 rsp_valid after reset", {63'd0, pred_rsp_valid}, 64'd0);
        check("R2 taken after reset", {63'd0, pred_taken}, 64'd0);
        check("R2 hist after reset", {42'd0, pred_hist}, 64'd0);

        // R2 R9: fresh tables predict not-taken for any address
        for (int i = 0; i < 6; i++) predict(CIW'(i * 97), "R2 R9 fresh");

        // R6: restore, including priority over a same-cycle request
        step(1'b1, 10'd3, 1'b1, 10'd7, 1'b1, 22'h2AAAA5, 1'b1, "R6 restore vs predict");
        predict(10'd3, "R6 after restore");
        predict(10'd4, "R5 shift chain");
        predict(10'd5, "R5 shift chain");

        // R10: update without mispredict keeps the history
        train(10'd9, 1'b1, 22'h155555, 1'b0, "R10 quiet update");
        idle();
        predict(10'd9, "R10 history held");

        // R7: saturating training of one direction counter
        load_hist(22'h00F0F0, 10'd1);
        for (int i = 0; i < 5; i++) train(10'd5, 1'b1, 22'h00F0F0, 1'b0, "R7 train up");
        load_hist(22'h00F0F0, 10'd1);
        predict(10'd5, "R7 saturated up");
        for (int i = 0; i < 5; i++) train(10'd5, 1'b0, 22'h00F0F0, 1'b0, "R7 train down");
        load_hist(22'h00F0F0, 10'd1);
        predict(10'd5, "R7 saturated down");

        // R8: steering held when the chosen table was right
        train(10'd20, 1'b1, 22'h000300, 1'b0, "R8 setup");
        train(10'd21, 1'b1, 22'h000300, 1'b0, "R8 exception");
        train(10'd21, 1'b0, 22'h000300, 1'b0, "R8 follow-up");
        load_hist(22'h000300, 10'd2);
        predict(10'd21 ^ 10'h300 ^ 10'h300, "R8 steering kept");
        load_hist(22'h000300, 10'd2);
        predict(10'd20, "R8 other steering entry");

        // R3 R4 R7 R8: random aliasing traffic
        for (int n = 0; n < 3000; n++) begin
            logic [GW-1:0] h;
            h = GW'($urandom) & 22'h30000F;
            step(($urandom % 2) == 0, CIW'($urandom % 16),
                 ($urandom % 3) != 0, CIW'($urandom % 16), 1'($urandom),
                 h, ($urandom % 5) == 0, "R3 R4 R7 R8 random");
        end
        idle();
        idle();
        check("R1 all responses seen", 64'(q_dir.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule